// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Burst Address Counters

This block is a shared memory with two fully independent ports. Each port has its own clock and can read or write any word of a common array at the same time as the other port. Words are 36 bits wide by default. The depth is a power of two set by the address-width parameter. Every port captures its controls, address and write data on the rising edge of its clock. The captured address comes from a per-port burst counter. That counter is cleared, loaded from the address pins, stepped by one, or held, so a port can stream through consecutive words without presenting a new address each cycle.

A static mode input, common to both ports, selects how read data leaves the block. In flow-through mode the word at the captured address is driven in the cycle right after the capturing edge. In pipelined mode the word passes through one more register and appears one cycle later. Each port has an active-low chip enable. When the chip enable is sampled high, that access neither writes nor drives data, and the port's read output is zero.

Collisions resolve in a fixed way. If both ports write the same word in the same cycle, port A's data is kept. A read that meets a write from either port in the same cycle returns the word's previous contents.

Top module: `dpram_burst`

## Requirements
- R1: A word written through either port can later be read back through either port.
- R2: Controls, address and write data are captured on the rising clock edge. A write captured at one edge updates the array at the next edge of that port's clock.
- R3: With `flow_mode`=1 (flow-through), `rdata_*` carries the word at the address captured at an edge during the cycle that follows that edge.
- R4: With `flow_mode`=0 (pipelined), the same word appears one clock cycle later than in flow-through mode.
- R5: `clr_n_*` low at an edge sets the port's address to 0. This overrides a simultaneous load or step.
- R6: `ld_n_*` low with `clr_n_*` high loads the port's address from `addr_*`.
- R7: `adv_n_*` low with `clr_n_*` and `ld_n_*` high adds one to the port's address, and `addr_*` is ignored.
- R8: A step from the last word (2^ADDR_W − 1) moves to address 0.
- R9: With `clr_n_*`, `ld_n_*` and `adv_n_*` all high, the port keeps accessing the same address.
- R10: An access captured with `ce_n_*` high writes nothing and reads as zero. In pipelined mode the output stays zero until the second edge after `ce_n_*` returns low.
- R11: When both ports write the same word in the same cycle, the word holds port A's data afterwards.
- R12: A read of a word that is being written in the same cycle returns the word's previous contents.
- R13: During and right after reset, both burst counters are 0 and both read outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset for both ports |
| flow_mode | input | 1 | 1 = flow-through read, 0 = pipelined read |
| ce_n_a | input | 1 | Port A chip enable, active low |
| we_a | input | 1 | Port A write enable, 1 = write |
| ld_n_a | input | 1 | Port A counter load from `addr_a`, active low |
| adv_n_a | input | 1 | Port A counter step, active low |
| clr_n_a | input | 1 | Port A counter clear, active low |
| addr_a | input | ADDR_W | Port A external address |
| wdata_a | input | DATA_W | Port A write data |
| rdata_a | output | DATA_W | Port A read data |
| ce_n_b | input | 1 | Port B chip enable, active low |
| we_b | input | 1 | Port B write enable, 1 = write |
| ld_n_b | input | 1 | Port B counter load from `addr_b`, active low |
| adv_n_b | input | 1 | Port B counter step, active low |
| clr_n_b | input | 1 | Port B counter clear, active low |
| addr_b | input | ADDR_W | Port B external address |
| wdata_b | input | DATA_W | Port B write data |
| rdata_b | output | DATA_W | Port B read data |

## Verification
A write presented at edge k changes the array at edge k+1. A read captured at edge k is due in the cycle after edge k in flow-through mode and in the cycle after edge k+1 in pipelined mode. A deselect takes effect on that same schedule. The bench model applies, at each edge, the pending writes and the pipeline register load, then captures the new inputs, all in that order. It compares both read outputs 2 ns after every rising edge, while inputs change only on falling edges. Words never written are tracked as unknown and left uncompared.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

   localparam int unsigned NUM_PORTS = 2;

   typedef enum logic [1:0] {
      CTR_HOLD = 2'd0,
      CTR_STEP = 2'd1,
      CTR_LOAD = 2'd2,
      CTR_ZERO = 2'd3
   } ctr_op_e;

   // clear beats load, load beats step, step beats hold
   function automatic ctr_op_e ctr_decode(input logic clr_n,
                                          input logic ld_n,
                                          input logic adv_n);
      ctr_op_e op;
      if (!clr_n)      op = CTR_ZERO;
      else if (!ld_n)  op = CTR_LOAD;
      else if (!adv_n) op = CTR_STEP;
      else             op = CTR_HOLD;
      return op;
   endfunction

endpackage

// File: rtl/dpb_port_front.sv
module dpb_port_front
   import dpb_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we,
   input  logic              ld_n,
   input  logic              adv_n,
   input  logic              clr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [ADDR_W-1:0] cnt_q,
   output logic              sel_q,
   output logic              wr_q,
   output logic [DATA_W-1:0] wdata_q
);

   ctr_op_e           op;
   logic [ADDR_W-1:0] cnt_d;

   always_comb begin
      op = ctr_decode(clr_n, ld_n, adv_n);
      unique case (op)
         CTR_ZERO: cnt_d = '0;
         CTR_LOAD: cnt_d = addr;
         CTR_STEP: cnt_d = cnt_q + 1'b1;   // natural wrap at the array end
         default:  cnt_d = cnt_q;
      endcase
   end

   // the counter doubles as the captured access address
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         sel_q   <= 1'b0;
         wr_q    <= 1'b0;
         wdata_q <= '0;
      end else begin
         cnt_q   <= cnt_d;
         sel_q   <= ~ce_n;
         wr_q    <= we;
         wdata_q <= wdata;
      end
   end

endmodule

// File: rtl/dpb_bank.sv
module dpb_bank #(
   parameter int ADDR_W     = 6,
   parameter int DATA_W     = 36,
   parameter bit INVERT_TAG = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic                   peer_tag,
   input  logic [1:0][ADDR_W-1:0] rd_addr,
   output logic [1:0][DATA_W-1:0] rd_data,
   output logic [1:0]             rd_tag
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] data_mem [DEPTH];
   logic [DEPTH-1:0]  tag_mem;
   logic              wr_tag;

   // bank A copies the peer tag (tags equal -> A newest),
   // bank B inverts it (tags differ -> B newest)
   generate
      if (INVERT_TAG) begin : g_inv
         assign wr_tag = ~peer_tag;
      end else begin : g_copy
         assign wr_tag = peer_tag;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) data_mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tag_mem          <= '0;
      else if (wr_en) tag_mem[wr_addr] <= wr_tag;
   end

   generate
      for (genvar r = 0; r < 2; r++) begin : g_rd
         assign rd_data[r] = data_mem[rd_addr[r]];
         assign rd_tag[r]  = tag_mem[rd_addr[r]];
      end
   endgenerate

endmodule

// File: rtl/dpb_read_out.sv
module dpb_read_out #(
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flow_mode,
   input  logic              sel_q,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] gated;
   logic [DATA_W-1:0] out_q;

   assign gated = sel_q ? word : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= '0;
      else        out_q <= gated;
   end

   assign rdata = flow_mode ? gated : out_q;

endmodule

// File: rtl/dpram_burst.sv
module dpram_burst
   import dpb_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 36
) (
   input  logic              clk_a,
   input  logic              clk_b,
   input  logic              rst_n,
   input  logic              flow_mode,
   input  logic              ce_n_a,
   input  logic              we_a,
   input  logic              ld_n_a,
   input  logic              adv_n_a,
   input  logic              clr_n_a,
   input  logic [ADDR_W-1:0] addr_a,
   input  logic [DATA_W-1:0] wdata_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic              ce_n_b,
   input  logic              we_b,
   input  logic              ld_n_b,
   input  logic              adv_n_b,
   input  logic              clr_n_b,
   input  logic [ADDR_W-1:0] addr_b,
   input  logic [DATA_W-1:0] wdata_b,
   output logic [DATA_W-1:0] rdata_b
);

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("dpram_burst: DATA_W must be at least 1");
      end
      if (ADDR_W < 1 || ADDR_W > 20) begin : g_bad_addr
         $error("dpram_burst: ADDR_W must lie in 1..20");
      end
      if (NUM_PORTS != 2) begin : g_bad_ports
         $error("dpram_burst: exactly two ports are supported");
      end
   endgenerate

   logic [1:0]             clk_v, ce_n_v, we_v, ld_n_v, adv_n_v, clr_n_v;
   logic [1:0][ADDR_W-1:0] addr_v, cnt_q;
   logic [1:0][DATA_W-1:0] wdata_v, wdata_q, word, rdata_v;
   logic [1:0]             sel_q, wr_q, wr_go;
   logic                   wr_go_a, wr_go_b;
   logic [1:0][1:0][DATA_W-1:0] bank_rd;   // [bank][reading port]
   logic [1:0][1:0]             bank_tag;  // [bank][reading port]
   logic [ADDR_W-1:0]      cnt_a;

   assign clk_v   = {clk_b,   clk_a};
   assign ce_n_v  = {ce_n_b,  ce_n_a};
   assign we_v    = {we_b,    we_a};
   assign ld_n_v  = {ld_n_b,  ld_n_a};
   assign adv_n_v = {adv_n_b, adv_n_a};
   assign clr_n_v = {clr_n_b, clr_n_a};
   assign addr_v  = {addr_b,  addr_a};
   assign wdata_v = {wdata_b, wdata_a};

   // port A wins a same-word write; port B's write is dropped
   assign wr_go_a = sel_q[0] & wr_q[0];
   assign wr_go_b = sel_q[1] & wr_q[1] & ~(wr_go_a && (cnt_q[0] == cnt_q[1]));
   assign wr_go   = {wr_go_b, wr_go_a};

   generate
      for (genvar p = 0; p < 2; p++) begin : g_port
         dpb_port_front #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
         ) i_front (
            .clk     (clk_v[p]),
            .rst_n   (rst_n),
            .ce_n    (ce_n_v[p]),
            .we      (we_v[p]),
            .ld_n    (ld_n_v[p]),
            .adv_n   (adv_n_v[p]),
            .clr_n   (clr_n_v[p]),
            .addr    (addr_v[p]),
            .wdata   (wdata_v[p]),
            .cnt_q   (cnt_q[p]),
            .sel_q   (sel_q[p]),
            .wr_q    (wr_q[p]),
            .wdata_q (wdata_q[p])
         );

         dpb_bank #(
            .ADDR_W     (ADDR_W),
            .DATA_W     (DATA_W),
            .INVERT_TAG (p == 1)
         ) i_bank (
            .clk      (clk_v[p]),
            .rst_n    (rst_n),
            .wr_en    (wr_go[p]),
            .wr_addr  (cnt_q[p]),
            .wr_data  (wdata_q[p]),
            .peer_tag (bank_tag[1-p][p]),
            .rd_addr  (cnt_q),
            .rd_data  (bank_rd[p]),
            .rd_tag   (bank_tag[p])
         );

         // equal tags: bank A holds the newest copy of the word
         assign word[p] = (bank_tag[0][p] == bank_tag[1][p]) ? bank_rd[0][p]
                                                             : bank_rd[1][p];

         dpb_read_out #(
            .DATA_W (DATA_W)
         ) i_out (
            .clk       (clk_v[p]),
            .rst_n     (rst_n),
            .flow_mode (flow_mode),
            .sel_q     (sel_q[p]),
            .word      (word[p]),
            .rdata     (rdata_v[p])
         );
      end
   endgenerate

   assign rdata_a = rdata_v[0];
   assign rdata_b = rdata_v[1];
   assign cnt_a   = cnt_q[0];

endmodule

// File: rtl/dpram_burst_chk.sv
module dpram_burst_chk #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 36
) (
   input logic              clk_a,
   input logic              clk_b,
   input logic              rst_n,
   input logic              flow_mode,
   input logic              ce_n_a,
   input logic              ce_n_b,
   input logic              ld_n_a,
   input logic              adv_n_a,
   input logic              clr_n_a,
   input logic [ADDR_W-1:0] addr_a,
   input logic [DATA_W-1:0] rdata_a,
   input logic [DATA_W-1:0] rdata_b,
   input logic [ADDR_W-1:0] cnt_a
);

   AST_CLR_WINS: assert property (@(posedge clk_a) disable iff (!rst_n)
      !clr_n_a |=> cnt_a == '0);                                        // R5

   AST_LOAD_ADDR: assert property (@(posedge clk_a) disable iff (!rst_n)
      (clr_n_a && !ld_n_a) |=> cnt_a == $past(addr_a));                 // R6

   AST_STEP_WRAP: assert property (@(posedge clk_a) disable iff (!rst_n)
      (clr_n_a && ld_n_a && !adv_n_a)
         |=> cnt_a == ADDR_W'($past(cnt_a) + 1'b1));                    // R7

   AST_HOLD_ADDR: assert property (@(posedge clk_a) disable iff (!rst_n)
      (clr_n_a && ld_n_a && adv_n_a) |=> $stable(cnt_a));               // R9

   AST_DESEL_FLOW_A: assert property (@(posedge clk_a) disable iff (!rst_n)
      (flow_mode && $past(ce_n_a)) |-> rdata_a == '0);                  // R10

   AST_DESEL_PIPE_A: assert property (@(posedge clk_a) disable iff (!rst_n)
      (!flow_mode && $past(ce_n_a)) |=> (flow_mode || rdata_a == '0));  // R10

   AST_DESEL_FLOW_B: assert property (@(posedge clk_b) disable iff (!rst_n)
      (flow_mode && $past(ce_n_b)) |-> rdata_b == '0);                  // R10

endmodule

bind dpram_burst dpram_burst_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) i_dpram_burst_chk (.*);

// File: tb/test_dpram_burst.sv
`timescale 1ns/1ps
module test_dpram_burst;

   localparam int AW    = 6;
   localparam int DW    = 36;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flow = 1'b1;
   logic          ce_n [2];
   logic          we   [2];
   logic          ld_n [2];
   logic          adv_n[2];
   logic          clr_n[2];
   logic [AW-1:0] addr [2];
   logic [DW-1:0] wd   [2];
   logic [DW-1:0] rd_a, rd_b;

   int    checks = 0;
   int    errors = 0;
   bit    done   = 1'b0;
   string tag    = "R13";

   always #4 clk = ~clk;   // 125 MHz

   dpram_burst #(.ADDR_W(AW), .DATA_W(DW)) i_dpram_burst (
      .clk_a(clk), .clk_b(clk), .rst_n(rst_n), .flow_mode(flow),
      .ce_n_a(ce_n[0]), .we_a(we[0]), .ld_n_a(ld_n[0]), .adv_n_a(adv_n[0]),
      .clr_n_a(clr_n[0]), .addr_a(addr[0]), .wdata_a(wd[0]), .rdata_a(rd_a),
      .ce_n_b(ce_n[1]), .we_b(we[1]), .ld_n_b(ld_n[1]), .adv_n_b(adv_n[1]),
      .clr_n_b(clr_n[1]), .addr_b(addr[1]), .wdata_b(wd[1]), .rdata_b(rd_b)
   );

   // behavioural reference
   logic [DW-1:0] m_mem  [DEPTH];
   bit            m_known[DEPTH];
   int            m_cnt [2];
   bit            m_act [2];
   bit            m_wr  [2];
   logic [DW-1:0] m_wd  [2];
   logic [DW-1:0] m_pq  [2];
   bit            m_pk  [2];

   task automatic model_edge();
      logic [DW-1:0] nq [2];
      bit            nk [2];
      bit            wa, wb;
      if (!rst_n) begin
         for (int p = 0; p < 2; p++) begin
            m_cnt[p] = 0; m_act[p] = 0; m_wr[p] = 0; m_pq[p] = '0; m_pk[p] = 1;
         end
         return;
      end
      for (int p = 0; p < 2; p++) begin
         nq[p] = m_act[p] ? m_mem[m_cnt[p]] : '0;
         nk[p] = m_act[p] ? m_known[m_cnt[p]] : 1'b1;
      end
      wa = m_act[0] && m_wr[0];
      wb = m_act[1] && m_wr[1] && !(wa && m_cnt[0] == m_cnt[1]);
      if (wb) begin m_mem[m_cnt[1]] = m_wd[1]; m_known[m_cnt[1]] = 1; end
      if (wa) begin m_mem[m_cnt[0]] = m_wd[0]; m_known[m_cnt[0]] = 1; end
      for (int p = 0; p < 2; p++) begin
         m_pq[p] = nq[p];
         m_pk[p] = nk[p];
         if (!clr_n[p])      m_cnt[p] = 0;
         else if (!ld_n[p])  m_cnt[p] = int'(addr[p]);
         else if (!adv_n[p]) m_cnt[p] = (m_cnt[p] + 1) % DEPTH;
         m_act[p] = !ce_n[p];
         m_wr[p]  = we[p];
         m_wd[p]  = wd[p];
      end
   endtask

   task automatic compare(input int p, input logic [DW-1:0] act);
      logic [DW-1:0] exp;
      bit            kn;
      if (flow) begin
         exp = m_act[p] ? m_mem[m_cnt[p]] : '0;
         kn  = m_act[p] ? m_known[m_cnt[p]] : 1'b1;
      end else begin
         exp = m_pq[p];
         kn  = m_pk[p];
      end
      if (!kn) return;
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s port %0d rdata actual %h expected %h", tag, p, act, exp);
      end
   endtask

   always @(posedge clk) begin
      model_edge();
      #2;
      if (!done) begin
         compare(0, rd_a);
         compare(1, rd_b);
      end
   end

   task automatic idle(input int p);
      ce_n[p] = 1; we[p] = 0; ld_n[p] = 1; adv_n[p] = 1; clr_n[p] = 1;
      addr[p] = '0; wd[p] = '0;
   endtask

   task automatic drive(input int p, input bit c_n, input bit w, input bit l_n,
                        input bit a_n, input bit z_n, input int ad,
                        input logic [DW-1:0] d);
      ce_n[p] = c_n; we[p] = w; ld_n[p] = l_n; adv_n[p] = a_n; clr_n[p] = z_n;
      addr[p] = AW'(ad); wd[p] = d;
   endtask

   function automatic logic [DW-1:0] pat(input int i);
      return {4'hA, 32'(i) * 32'h0101_0101 ^ 32'h5A5A_0000};
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) begin m_known[i] = 0; m_mem[i] = '0; end
      idle(0); idle(1);
      // R13: reset state
      tag = "R13";
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // fill the array through port A: load then step, wrap at the end
      tag = "R6";
      drive(0, 0, 1, 0, 1, 1, 0, pat(0));
      tick(1);
      tag = "R7";
      for (int i = 1; i <= DEPTH; i++) begin
         if (i == DEPTH) tag = "R8";
         drive(0, 0, 1, 1, 0, 1, (i * 37) % DEPTH, pat(i));
         tick(1);
      end
      idle(0);
      tick(1);

      // R1 / R3: flow-through reads on both ports, B wraps past the end
      tag = "R3";
      drive(0, 0, 0, 0, 1, 1, 5, '0);
      drive(1, 0, 0, 0, 1, 1, 60, '0);
      tick(1);
      tag = "R1";
      for (int i = 0; i < 8; i++) begin
         drive(0, 0, 0, 1, 0, 1, 17, '0);
         drive(1, 0, 0, 1, 0, 1, 9, '0);
         tick(1);
      end
      // R9: hold keeps the same word
      tag = "R9";
      drive(1, 0, 0, 1, 1, 1, 44, '0);
      tick(3);
      // R5: clear overrides a simultaneous load
      tag = "R5";
      drive(1, 0, 0, 0, 0, 0, 33, '0);
      tick(1);
      drive(1, 0, 0, 1, 1, 1, 33, '0);
      tick(2);

      // R4: pipelined reads
      idle(0); idle(1);
      tick(1);
      flow = 1'b0;
      tick(1);
      tag = "R4";
      drive(0, 0, 0, 0, 1, 1, 20, '0);
      drive(1, 0, 0, 0, 1, 1, 10, '0);
      tick(1);
      for (int i = 0; i < 5; i++) begin
         drive(0, 0, 0, 1, 0, 1, 0, '0);
         drive(1, 0, 0, 1, 0, 1, 0, '0);
         tick(1);
      end

      // R10: deselect mid-burst, and a write while deselected
      tag = "R10";
      drive(1, 1, 0, 1, 0, 1, 0, '0);
      drive(0, 1, 1, 0, 1, 1, 3, 36'hD_EAD0_BEEF);
      tick(1);
      drive(1, 0, 0, 1, 0, 1, 0, '0);
      drive(0, 0, 0, 1, 1, 1, 0, '0);
      tick(4);

      // R11: both ports write word 12 in the same cycle
      tag = "R11";
      drive(0, 0, 1, 0, 1, 1, 12, 36'h1_1111_1111);
      drive(1, 0, 1, 0, 1, 1, 12, 36'h2_2222_2222);
      tick(1);
      drive(0, 0, 0, 1, 1, 1, 0, '0);
      drive(1, 0, 0, 1, 1, 1, 0, '0);
      tick(4);

      // R12 / R2 in flow-through
      idle(0); idle(1);
      tick(1);
      flow = 1'b1;
      tick(1);
      tag = "R12";
      drive(0, 0, 1, 0, 1, 1, 40, 36'h3_3333_3333);
      drive(1, 0, 0, 0, 1, 1, 40, '0);
      tick(1);
      drive(0, 1, 0, 1, 1, 1, 0, '0);
      drive(1, 0, 0, 1, 1, 1, 0, '0);
      tick(2);
      tag = "R2";
      drive(0, 0, 1, 0, 1, 1, 50, 36'h4_4444_4444);
      idle(1);
      tick(1);
      drive(0, 0, 0, 1, 1, 1, 0, '0);
      tick(3);
      tag = "R1";
      drive(0, 1, 0, 1, 1, 1, 0, '0);
      drive(1, 0, 0, 0, 1, 1, 50, '0);
      tick(3);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL %s watchdog actual hung expected finished", tag);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule